// File: doc/BRIEF.md
# NRZI Serial Receiver with Oversampled Phase Tracking

This block takes in a serial line that arrives with no clock and recovers its bits. The line runs at a nominal 20 Mbps. The receiver clock runs at `OVS` times the bit rate, with a default of four. The line first passes through a two-stage synchronizer. A phase counter then marks where the next bit boundary is expected. Each level change on the line is compared with that expected position. The change is graded as on time, late, early or out of range. A late or early change moves the counter by one sample. This lets the receiver follow a transmitter whose clock is slightly fast or slow.

One decision is taken per bit period, at the sample halfway between expected boundaries. Decisions are NRZI-decoded: a level change since the previous decision gives a one, and an unchanged level gives a zero. The transmitter inserts a one after every six zeros. The receiver removes that inserted one. If a seventh zero appears where the inserted one should be, the receiver flags a stuffing error.

Decoded bits appear on `bit_out` with a one-cycle `bit_valid` strobe, but only while `locked` is high. Lock is gained after `LOCK_COUNT` consecutive on-time transitions. It is lost when a transition is out of range or when a stuffing error occurs.

Top module: `nrzi_cdr_rx`

## Requirements
- R1: While reset is high and in the first cycle after it, `locked`, `bit_valid`, `stuff_err` and `phase_err` are all low.
- R2: The line passes through a two-flop synchronizer. With `OVS` samples per bit (even, at least 4), the bit decision uses the sample taken `OVS/2` samples after the expected boundary. At the nominal rate, the recovered bit sequence equals the transmitted payload.
- R3: A level change between two successive decisions decodes as 1. No change decodes as 0.
- R4: After six consecutive decoded zeros, the next decoded one is an inserted bit. It is dropped and produces no `bit_valid`.
- R5: A change seen `k` samples after the expected boundary is graded as follows. It is on time for k=0 and late for 0<k<OVS/2. It is an error for k=OVS/2 and early for k>OVS/2. For late and early changes, the next sample becomes phase 1, and lock is kept. A payload sent with one bit in every eight shortened or lengthened by one sample decodes correctly and never drops lock.
- R6: An error-graded change pulses `phase_err` for one cycle and clears `locked` in the same cycle. The next change seen re-anchors the phase counter, and then `LOCK_COUNT` further on-time changes restore lock.
- R7: After reset, the first change re-anchors the phase. `locked` rises on the `LOCK_COUNT`-th consecutive on-time change after that, and not before.
- R8: A seventh decoded zero at a point where an inserted one was due pulses `stuff_err` for one cycle. `locked` is low in the following cycle. `stuff_err` and `bit_valid` are never high together.
- R9: `bit_valid` is high only if `locked` was high in the cycle before. Two strobes are at least three cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, OVS times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous NRZI serial line |
| bit_out | output | 1 | Recovered logical bit |
| bit_valid | output | 1 | One-cycle strobe qualifying `bit_out` |
| locked | output | 1 | Phase tracking is locked |
| stuff_err | output | 1 | Pulse: missing inserted one after six zeros |
| phase_err | output | 1 | Pulse: transition at the half-bit position |

## Verification
The properties assume that the line holds each level for at least about one bit period minus one sample. They also assume that the far-end clock drifts by no more than one sample between transitions. Under those conditions, decisions are spaced three or more cycles apart and lock changes only for the reasons stated. The stimulus changes the line only on falling clock edges. It holds every bit for exactly four samples, except for one shortened or lengthened bit in every eight, and the bit-stuffing rule guarantees a transition at least every seven bits. The out-of-range cases are produced on purpose: a two-sample bit creates the error-graded transition, and a run of seven unstuffed zeros creates the stuffing error.

// File: rtl/nrzi_cdr_pkg.sv
package nrzi_cdr_pkg;

    // Grading of a line transition against the expected bit boundary
    typedef enum logic [1:0] {
        EDGE_ON_TIME,
        EDGE_LATE,
        EDGE_EARLY,
        EDGE_BAD
    } edge_kind_e;

    // Phase tracker state
    typedef enum logic {
        TRK_ACQUIRE,
        TRK_FOLLOW
    } trk_state_e;

    // One bit decision handed from the tracker to the decoder
    typedef struct packed {
        logic stb;
        logic lvl;
    } decision_t;

    // ph = sample offset of the transition from the expected boundary
    function automatic edge_kind_e classify_edge(input int unsigned ph,
                                                 input int unsigned ovs);
        if (ph == 0)
            return EDGE_ON_TIME;
        else if (ph < ovs / 2)
            return EDGE_LATE;
        else if (ph == ovs / 2)
            return EDGE_BAD;
        else
            return EDGE_EARLY;
    endfunction

endpackage

// File: rtl/cdr_sync.sv
module cdr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cdr_phase_track.sv
module cdr_phase_track
    import nrzi_cdr_pkg::*;
#(
    parameter int OVS        = 4,
    parameter int LOCK_COUNT = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      smp,
    input  logic      drop_lock,
    output decision_t dec,
    output logic      locked,
    output logic      phase_err
);
    localparam int PW  = $clog2(OVS);
    localparam int CW  = $clog2(LOCK_COUNT + 1);
    localparam int MID = OVS / 2;

    logic            smp_q;
    logic [PW-1:0]   ph_q;
    logic [PW-1:0]   ph_next;
    logic [CW-1:0]   cnt_q;
    trk_state_e      st_q;
    edge_kind_e      kind;
    logic            edge_seen;

    assign edge_seen = smp ^ smp_q;
    assign kind      = classify_edge(32'(ph_q), OVS);

    always_comb begin
        dec.stb = (ph_q == PW'(MID));
        dec.lvl = smp;
    end

    // Any accepted transition marks the current sample as phase 0
    always_comb begin
        if (edge_seen && (st_q == TRK_ACQUIRE || kind != EDGE_BAD))
            ph_next = PW'(1);
        else if (ph_q == PW'(OVS - 1))
            ph_next = '0;
        else
            ph_next = ph_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q     <= 1'b0;
            ph_q      <= '0;
            cnt_q     <= '0;
            st_q      <= TRK_ACQUIRE;
            locked    <= 1'b0;
            phase_err <= 1'b0;
        end else begin
            smp_q     <= smp;
            ph_q      <= ph_next;
            phase_err <= 1'b0;
            if (drop_lock) begin
                st_q   <= TRK_ACQUIRE;
                locked <= 1'b0;
                cnt_q  <= '0;
            end else if (edge_seen) begin
                if (st_q == TRK_ACQUIRE) begin
                    st_q  <= TRK_FOLLOW;
                    cnt_q <= '0;
                end else begin
                    unique case (kind)
                        EDGE_ON_TIME: begin
                            if (!locked) begin
                                if (cnt_q == CW'(LOCK_COUNT - 1))
                                    locked <= 1'b1;
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                        EDGE_LATE, EDGE_EARLY: begin
                            if (!locked)
                                cnt_q <= '0;
                        end
                        default: begin
                            st_q      <= TRK_ACQUIRE;
                            locked    <= 1'b0;
                            cnt_q     <= '0;
                            phase_err <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/cdr_nrzi_destuff.sv
module cdr_nrzi_destuff
    import nrzi_cdr_pkg::*;
#(
    parameter int STUFF_RUN = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  decision_t dec,
    input  logic      locked,
    output logic      bit_out,
    output logic      bit_valid,
    output logic      stuff_err
);
    localparam int RW = $clog2(STUFF_RUN + 1);

    logic          last_q;
    logic [RW-1:0] run_q;
    logic          bit_now;
    logic          at_limit;

    assign bit_now  = dec.lvl ^ last_q;
    assign at_limit = (run_q == RW'(STUFF_RUN));

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q    <= 1'b0;
            run_q     <= '0;
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
            stuff_err <= 1'b0;
        end else begin
            bit_valid <= 1'b0;
            stuff_err <= 1'b0;
            if (dec.stb) begin
                last_q <= dec.lvl;
                if (at_limit) begin
                    // inserted one is dropped; a zero here is a violation
                    run_q <= '0;
                    if (!bit_now)
                        stuff_err <= locked;
                end else begin
                    run_q     <= bit_now ? '0 : run_q + 1'b1;
                    bit_out   <= bit_now;
                    bit_valid <= locked;
                end
            end
        end
    end
endmodule

// File: rtl/nrzi_cdr_rx.sv
module nrzi_cdr_rx
    import nrzi_cdr_pkg::*;
#(
    parameter int OVS         = 4,
    parameter int LOCK_COUNT  = 4,
    parameter int STUFF_RUN   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_line,
    output logic bit_out,
    output logic bit_valid,
    output logic locked,
    output logic stuff_err,
    output logic phase_err
);
    logic      smp;
    decision_t dec;

    cdr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rx_line),
        .q   (smp)
    );

    cdr_phase_track #(.OVS(OVS), .LOCK_COUNT(LOCK_COUNT)) u_track (
        .clk       (clk),
        .rst       (rst),
        .smp       (smp),
        .drop_lock (stuff_err),
        .dec       (dec),
        .locked    (locked),
        .phase_err (phase_err)
    );

    cdr_nrzi_destuff #(.STUFF_RUN(STUFF_RUN)) u_destuff (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .locked    (locked),
        .bit_out   (bit_out),
        .bit_valid (bit_valid),
        .stuff_err (stuff_err)
    );
endmodule

// File: rtl/cdr_rx_checker.sv
module cdr_rx_checker (
    input logic clk,
    input logic rst,
    input logic bit_valid,
    input logic locked,
    input logic stuff_err,
    input logic phase_err
);
    // R9: a strobe follows a locked cycle
    assert_valid_needs_lock_R9: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> $past(locked));

    // R9: strobes are at least three cycles apart
    assert_valid_spacing_R9: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> (!$past(bit_valid) && !$past(bit_valid, 2)));

    // R8: stuffing violation removes lock next cycle
    assert_stuff_drops_lock_R8: assert property (@(posedge clk) disable iff (rst)
        stuff_err |=> !locked);

    // R8: violation and strobe are exclusive
    assert_err_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bit_valid, stuff_err}));

    // R6: phase error coincides with loss of lock
    assert_phase_err_unlocked_R6: assert property (@(posedge clk) disable iff (rst)
        phase_err |-> !locked);

    // R6: no strobe right after a phase error
    assert_phase_err_blocks_valid_R6: assert property (@(posedge clk) disable iff (rst)
        phase_err |=> !bit_valid);
endmodule

bind nrzi_cdr_rx cdr_rx_checker i_cdr_rx_checker (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .locked    (locked),
    .stuff_err (stuff_err),
    .phase_err (phase_err)
);

// File: tb/test_nrzi_cdr_rx.sv
module test_nrzi_cdr_rx;
    localparam int OVS        = 4;
    localparam int LOCK_COUNT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_line = 1'b0;
    logic bit_out, bit_valid, locked, stuff_err, phase_err;

    always #2.5 clk = ~clk;

    nrzi_cdr_rx #(.OVS(OVS), .LOCK_COUNT(LOCK_COUNT), .STUFF_RUN(6), .SYNC_STAGES(2)) i_nrzi_cdr_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_line   (rx_line),
        .bit_out   (bit_out),
        .bit_valid (bit_valid),
        .locked    (locked),
        .stuff_err (stuff_err),
        .phase_err (phase_err)
    );

    int checks = 0;
    int errors = 0;

    // mode 0 nominal, 1 every 8th bit one sample short, 2 one sample long
    typedef struct packed {
        logic [1:0]  mode;
        logic [5:0]  len;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 6'd16, 32'h0000_A5A4},
        '{2'd0, 6'd32, 32'h0100_0F00},
        '{2'd1, 6'd32, 32'h5555_5554},
        '{2'd2, 6'd32, 32'hF0F0_0F0E},
        '{2'd1, 6'd32, 32'h8000_4000},
        '{2'd2, 6'd32, 32'h0030_0C02},
        '{2'd0, 6'd24, 32'h0000_0000}
    };

    // monitor
    logic cap [0:127];
    int   cap_n = 0;
    bit   cap_en = 0;
    int   lock_falls = 0;
    int   perr_seen = 0;
    int   serr_seen = 0;
    int   valid_seen = 0;
    logic prev_lock = 1'b0;

    always @(negedge clk) begin
        if (cap_en && bit_valid && cap_n < 128) begin
            cap[cap_n] = bit_out;
            cap_n++;
        end
        if (bit_valid) valid_seen++;
        if (phase_err) perr_seen++;
        if (stuff_err) serr_seen++;
        if (prev_lock && !locked) lock_falls++;
        prev_lock = locked;
    end

    // line model
    logic line_lvl = 1'b0;
    int   bit_ctr = 0;
    int   zrun = 0;
    int   mode_g = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic line_bit(input logic b, input int dur);
        if (b) line_lvl = ~line_lvl;
        rx_line = line_lvl;
        hold(dur);
    endtask

    function automatic int dur_for(input int mode, input int idx);
        if (mode == 1 && (idx % 8) == 7) return OVS - 1;
        if (mode == 2 && (idx % 8) == 7) return OVS + 1;
        return OVS;
    endfunction

    task automatic send_raw(input logic b);
        line_bit(b, dur_for(mode_g, bit_ctr));
        bit_ctr++;
    endtask

    task automatic send_data(input logic b);
        send_raw(b);
        if (b) zrun = 0;
        else begin
            zrun++;
            if (zrun == 6) begin
                send_raw(1'b1);
                zrun = 0;
            end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        line_lvl = 1'b0;
        rx_line = 1'b0;
        mode_g = 0;
        hold(4);
        rst = 1'b0;
        zrun = 0;
        bit_ctr = 0;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);

        // ---- R1: reset state
        do_reset();
        hold(1);
        check(locked == 1'b0,    "R1", "locked after reset",    locked,    0);
        check(bit_valid == 1'b0, "R1", "bit_valid after reset", bit_valid, 0);
        check(stuff_err == 1'b0, "R1", "stuff_err after reset", stuff_err, 0);
        check(phase_err == 1'b0, "R1", "phase_err after reset", phase_err, 0);

        // ---- R7: lock after exactly LOCK_COUNT on-time edges past the anchor
        do_reset();
        valid_seen = 0;
        repeat (LOCK_COUNT) send_data(1'b1);
        check(locked == 1'b0, "R7", "locked one edge early", locked, 0);
        check(valid_seen == 0, "R9", "strobes while unlocked", valid_seen, 0);
        send_data(1'b1);
        check(locked == 1'b1, "R7", "locked at count", locked, 1);

        // ---- R6: half-bit transition
        repeat (4) send_data(1'b1);
        perr_seen = 0;
        line_bit(1'b1, OVS / 2);
        line_bit(1'b1, OVS);
        check(perr_seen == 1, "R6", "phase_err pulses", perr_seen, 1);
        check(locked == 1'b0, "R6", "lock after bad edge", locked, 0);
        repeat (LOCK_COUNT) line_bit(1'b1, OVS);
        check(locked == 1'b0, "R6", "lock before reacquire done", locked, 0);
        line_bit(1'b1, OVS);
        check(locked == 1'b1, "R6", "lock reacquired", locked, 1);

        // ---- R8: seven zeros with no inserted one
        repeat (3) send_data(1'b1);
        serr_seen = 0;
        lock_falls = 0;
        repeat (7) send_raw(1'b0);
        hold(4);
        check(serr_seen == 1, "R8", "stuff_err pulses", serr_seen, 1);
        check(locked == 1'b0, "R8", "lock after stuff error", locked, 0);
        check(lock_falls == 1, "R8", "lock falls", lock_falls, 1);

        // ---- vector table: payload recovery, stuffing, drift
        for (int v = 0; v < NV; v++) begin
            string tag;
            int    z;
            int    mism;
            int    len;
            tag = (VECS[v].mode == 2'd0) ? "R2 R3 R4" : "R5 R4";
            len = int'(VECS[v].len);
            do_reset();
            mode_g = int'(VECS[v].mode);
            repeat (12) send_data(1'b1);
            check(locked == 1'b1, "R7", "locked after preamble", locked, 1);
            cap_n = 0;
            lock_falls = 0;
            cap_en = 1;
            for (int i = 0; i < len; i++) send_data(VECS[v].data[i]);
            repeat (10) send_data(1'b1);
            hold(8);
            cap_en = 0;
            z = -1;
            for (int i = 0; i < cap_n; i++) begin
                if (cap[i] == 1'b0) begin
                    z = i;
                    break;
                end
            end
            mism = 0;
            if (z < 0 || z + len > cap_n) mism = 99;
            else begin
                for (int i = 0; i < len; i++)
                    if (cap[z + i] != VECS[v].data[i]) mism++;
            end
            check(mism == 0, tag, $sformatf("vector %0d bit mismatches", v), mism, 0);
            check(lock_falls == 0, tag, $sformatf("vector %0d lock losses", v), lock_falls, 0);
            check(serr_seen >= 0 && stuff_err == 1'b0, "R8", $sformatf("vector %0d stuff_err idle", v), stuff_err, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule